// File: doc/BRIEF.md
# Relocatable Peripheral Register Window Decoder

This block watches the processor's bus cycles and decides whether each one lands inside a 256-byte window of on-chip peripheral control registers. It looks at the address, the read and write strobes and the memory/I-O space flag. On a hit it raises a register select and gives the word index of the target register. The window holds 128 word-wide registers, and every access to the window moves a full 16-bit word. The peripherals behind the registers are not part of this block. They are stood in for by a plain register array inside it.

The window's own position is held in a relocation register, which is one of the 128 registers of the window. That register carries the base (address bits above the window offset) and a space bit that selects memory or I/O. Software moves the whole window at run time by writing that register. The new placement applies from the next bus cycle onward. The processor's external bus cycle is always signalled, whether or not the access hits the window.

Top module: `regwin_decoder`

## Requirements
- R1: After reset the relocation register reads 0x00FF: base 0x0FF in bits [11:0], space bit 12 clear meaning I/O space. The window therefore spans 0x0FF00..0x0FFFF in I/O space, and every peripheral register reads zero.
- R2: A strobed access hits when the access space matches the space bit (bus_io=1 with bit 12 clear, bus_io=0 with bit 12 set) and bus_addr[19:8] equals the base field. On a hit, reg_sel is high and reg_idx equals bus_addr[7:1] in the same cycle.
- R3: Address bit 0 does not affect decoding: an odd address selects and returns the same word as the even address below it.
- R4: A write hit stores all 16 bits of bus_wdata into the selected register. A later read hit of that register returns all 16 bits.
- R5: A miss, or a cycle without strobe, gives reg_sel low, reg_idx zero and rd_data zero, and a write miss leaves every register unchanged.
- R6: The relocation register is word index 127. A write hit stores the full 16-bit word there, and a read hit returns that word.
- R7: A relocation write is decoded against the old placement. The new base and space apply from the next cycle, so the old window misses from then on.
- R8: ext_cyc is high in every cycle with a read or write strobe, whether the access hits or misses, and low otherwise.
- R9: An access whose space flag differs from the window's space bit misses, even when its address bits match the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Bus cycle byte address |
| bus_io | input | 1 | 1 = I/O space cycle, 0 = memory space cycle |
| bus_rd | input | 1 | Read strobe (one cycle per access) |
| bus_wr | input | 1 | Write strobe (one cycle per access) |
| bus_wdata | input | 16 | Write data word |
| reg_sel | output | 1 | Window register selected this cycle |
| reg_idx | output | 7 | Word index of the selected register, zero on a miss |
| rd_data | output | 16 | Read word on a read hit, zero otherwise |
| ext_cyc | output | 1 | External bus cycle indicator |

## Verification
The decode outputs reg_sel, reg_idx, rd_data and ext_cyc are combinational and are due in the same cycle as the strobe. The bench drives each cycle at the falling edge and compares a short settle later, before the next rising edge. Register writes, including relocation writes, take effect at the rising edge that ends the strobe cycle, so their effect first shows on the following cycle. The reference model applies each write only after it has compared that cycle. This keeps a relocation write decoded against the old placement and checks its new placement from the next cycle onward.

// File: rtl/regwin_pkg.sv
// Package: shared constants and types for the register window decoder.
// Assumes a 20-bit byte address and 16-bit data words.
package regwin_pkg;

    // Address space encoding held in the relocation register's space bit.
    typedef enum logic {
        SPACE_IO  = 1'b0,
        SPACE_MEM = 1'b1
    } space_e;

    // Bit position of the space flag inside the relocation word.
    localparam int SPACE_BIT = 12;

endpackage

// File: rtl/regwin_match.sv
// regwin_match: compares a bus address and space against the current window
// placement and produces a hit flag and the word index.
// Assumes the window is 2**OFF_W bytes, aligned on its own size.
module regwin_match #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    is_io,
    input  logic                    strobe,
    input  logic [ADDR_W-OFF_W-1:0] base,
    input  regwin_pkg::space_e      space,
    output logic                    hit,
    output logic [OFF_W-2:0]        idx
);
    import regwin_pkg::*;

    logic space_ok;
    logic base_ok;

    // Space check: I/O cycles match an I/O window, memory cycles a memory window.
    always_comb begin
        space_ok = (is_io && (space == SPACE_IO)) || (!is_io && (space == SPACE_MEM));
    end

    // Base check on the address bits above the window offset.
    always_comb begin
        base_ok = (addr[ADDR_W-1:OFF_W] == base);
    end

    // Hit and word index; byte-lane bit 0 takes no part.
    always_comb begin
        hit = strobe && space_ok && base_ok;
        idx = hit ? addr[OFF_W-1:1] : '0;
    end

endmodule

// File: rtl/regwin_reloc.sv
// regwin_reloc: holds the relocation word that places the window.
// Assumes write enable is already qualified by a hit on the relocation index.
module regwin_reloc #(
    parameter int DATA_W   = 16,
    parameter int BASE_W   = 12,
    parameter logic [DATA_W-1:0] RESET_VAL = 16'h00FF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    value,
    output logic [BASE_W-1:0]    base,
    output regwin_pkg::space_e   space
);
    import regwin_pkg::*;

    logic [DATA_W-1:0] reloc_q;

    // Relocation word storage; new value seen by the decoder next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reloc_q <= RESET_VAL;
        end else if (we) begin
            reloc_q <= wdata;
        end
    end

    // Field extraction for the address matcher.
    always_comb begin
        value = reloc_q;
        base  = reloc_q[BASE_W-1:0];
        space = space_e'(reloc_q[SPACE_BIT]);
    end

endmodule

// File: rtl/regwin_regfile.sv
// regwin_regfile: stand-in for the peripherals, a bank of word registers
// with one write port and one combinational read port.
// Assumes write enable and index are already qualified by the decoder.
module regwin_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 128,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // One peripheral register, cleared by reset, written on an index match.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    // Combinational read port.
    always_comb begin
        rdata = regs_q[ridx];
    end

endmodule

// File: rtl/regwin_decoder.sv
// regwin_decoder: top of the relocatable register window. Decodes bus cycles
// against the relocation word, selects a word register, steers writes to the
// peripheral bank or the relocation register, and returns read data.
// Assumes at most one of bus_rd / bus_wr per cycle, one cycle per access.
module regwin_decoder #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int NREGS     = 128,
    parameter logic [DATA_W-1:0] RESET_RELOC = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              reg_sel,
    output logic [$clog2(NREGS)-1:0] reg_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              ext_cyc
);
    import regwin_pkg::*;

    localparam int IDX_W  = $clog2(NREGS);
    localparam int OFF_W  = IDX_W + 1;
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam logic [IDX_W-1:0] RELOC_IDX = IDX_W'(NREGS - 1);

    logic              strobe;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [BASE_W-1:0] cur_base;
    space_e            cur_space;
    logic [DATA_W-1:0] reloc_val;
    logic [DATA_W-1:0] file_rd;
    logic              is_reloc;
    logic              file_we;
    logic              reloc_we;

    // Any strobe marks a bus cycle; the external cycle always runs.
    always_comb begin
        strobe  = bus_rd || bus_wr;
        ext_cyc = strobe;
    end

    regwin_match #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_match (
        .addr   (bus_addr),
        .is_io  (bus_io),
        .strobe (strobe),
        .base   (cur_base),
        .space  (cur_space),
        .hit    (hit),
        .idx    (idx)
    );

    // Steer writes between the relocation word and the peripheral bank.
    always_comb begin
        is_reloc = (idx == RELOC_IDX);
        file_we  = bus_wr && hit && !is_reloc;
        reloc_we = bus_wr && hit && is_reloc;
    end

    regwin_reloc #(
        .DATA_W    (DATA_W),
        .BASE_W    (BASE_W),
        .RESET_VAL (RESET_RELOC)
    ) u_reloc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reloc_we),
        .wdata (bus_wdata),
        .value (reloc_val),
        .base  (cur_base),
        .space (cur_space)
    );

    regwin_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS),
        .IDX_W  (IDX_W)
    ) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (file_we),
        .widx  (idx),
        .wdata (bus_wdata),
        .ridx  (idx),
        .rdata (file_rd)
    );

    // Select, index and read data returned to the bus.
    always_comb begin
        reg_sel = hit;
        reg_idx = idx;
        if (bus_rd && hit) begin
            rd_data = is_reloc ? reloc_val : file_rd;
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/regwin_checker.sv
// regwin_checker: protocol checks for regwin_decoder, attached by bind.
// Assumes the relocation word is visible as reloc_val in the bound scope.
module regwin_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7,
    parameter logic [DATA_W-1:0] RESET_RELOC = 16'h00FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_io,
    input logic              reg_sel,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              ext_cyc,
    input logic [DATA_W-1:0] reloc_val
);
    localparam int OFF_W = IDX_W + 1;

    // R1: reset loads the default placement.
    a_r1_reset_place: assert property (@(posedge clk)
        !rst_n |=> reloc_val == RESET_RELOC);

    // R2: a selected register's index follows address bits above bit 0.
    a_r2_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_idx == bus_addr[OFF_W-1:1]) && (bus_addr[ADDR_W-1:OFF_W] == reloc_val[ADDR_W-OFF_W-1:0]));

    // R5: no select means zero index and zero read data.
    a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_idx == '0) && (rd_data == '0));

    // R8: every strobe is passed to the external bus.
    a_r8_ext_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> ext_cyc);

    // R7: relocation word changes only after a write hit on the last index.
    a_r7_reloc_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && reg_sel && (reg_idx == {IDX_W{1'b1}})) |=> $stable(reloc_val));

    // R9: a space mismatch never selects.
    a_r9_space_gate: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (bus_io != reloc_val[12]));

endmodule

bind regwin_decoder regwin_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .IDX_W       ($clog2(NREGS)),
    .RESET_RELOC (RESET_RELOC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_io    (bus_io),
    .reg_sel   (reg_sel),
    .reg_idx   (reg_idx),
    .rd_data   (rd_data),
    .ext_cyc   (ext_cyc),
    .reloc_val (reloc_val)
);

// File: tb/sim_regwin_decoder.sv
// Bench: behavioural reference model compared every cycle.
module sim_regwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_io = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        reg_sel;
    logic [6:0]  reg_idx;
    logic [15:0] rd_data;
    logic        ext_cyc;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference state
    int mdl_regs [128];
    int mdl_reloc;

    always #10 clk = ~clk;

    regwin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .reg_sel(reg_sel), .reg_idx(reg_idx), .rd_data(rd_data), .ext_cyc(ext_cyc)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, compare, then update the model.
    task automatic cyc(input bit rd, input bit wr, input bit io,
                       input int addr, input int wd, input string tag);
        int base, hit, idx, exp_rd, strobe;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_io = io;
        bus_addr = 20'(addr); bus_wdata = 16'(wd);
        #2;
        base   = mdl_reloc & 'hFFF;
        strobe = rd || wr;
        hit    = strobe && (io == !((mdl_reloc >> 12) & 1)) && (((addr >> 8) & 'hFFF) == base);
        idx    = hit ? ((addr >> 1) & 'h7F) : 0;
        exp_rd = 0;
        if (rd && hit) exp_rd = (idx == 127) ? mdl_reloc : mdl_regs[idx];
        check({tag, " sel"}, int'(reg_sel), hit);
        check({tag, " idx"}, int'(reg_idx), idx);
        check({tag, " rdata"}, int'(rd_data), exp_rd);
        check({"R8 ", tag, " ext"}, int'(ext_cyc), strobe);
        if (wr && hit) begin
            if (idx == 127) mdl_reloc = wd & 'hFFFF;
            else mdl_regs[idx] = wd & 'hFFFF;
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mdl_regs[i] = 0;
        mdl_reloc = 'h00FF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: default placement and cleared registers
        cyc(1, 0, 1, 'h0FFFE, 0, "R1 reloc readback");
        cyc(1, 0, 1, 'h0FF00, 0, "R1 reg0 zero");
        cyc(0, 0, 1, 'h0FF00, 0, "R5 idle");
        // R2 R4: write and read back full words
        cyc(0, 1, 1, 'h0FF10, 'hA5A5, "R4 write");
        cyc(1, 0, 1, 'h0FF10, 0, "R4 read");
        cyc(1, 0, 1, 'h0FF11, 0, "R3 odd address");
        cyc(0, 1, 1, 'h0FF23, 'h1234, "R3 odd write");
        cyc(1, 0, 1, 'h0FF22, 0, "R3 even read");
        // R5 R9: misses leave state unchanged
        cyc(0, 1, 1, 'h0FE10, 'hFFFF, "R5 write miss");
        cyc(0, 1, 0, 'h0FF10, 'hFFFF, "R9 space miss");
        cyc(1, 0, 0, 'h0FF10, 0, "R9 read miss");
        cyc(1, 0, 1, 'h0FF10, 0, "R5 unchanged");
        // R6 R7: move window to memory base 0x123
        cyc(0, 1, 1, 'h0FFFF, 'h1123, "R7 reloc write");
        cyc(1, 0, 1, 'h0FF10, 0, "R7 old window misses");
        cyc(1, 0, 0, 'h12310, 0, "R7 new window");
        cyc(1, 0, 0, 'h123FE, 0, "R6 reloc readback");
        cyc(1, 0, 1, 'h12310, 0, "R9 io at mem window");
        cyc(0, 1, 0, 'h12380, 'hBEEF, "R2 write new place");
        // back to I/O at base 0x0AB with extra upper bits
        cyc(0, 1, 0, 'h123FE, 'hE0AB, "R6 reloc write io");
        cyc(1, 0, 1, 'h0AB80, 0, "R7 io window");
        cyc(1, 0, 1, 'h0ABFF, 0, "R6 reloc full word");
        // sweep of patterns
        for (int i = 0; i < 127; i++)
            cyc(0, 1, 1, 'h0AB00 + 2 * i, (i * 'h9E37) ^ 'h5A5A, "R4 sweep write");
        for (int i = 0; i < 127; i++)
            cyc(1, 0, 1, 'h0AB01 + 2 * i, 0, "R2 sweep read");
        for (int i = 0; i < 16; i++)
            cyc(i % 2, (i + 1) % 2, i % 3 == 0, 'h0AB00 + 16 * i, i, "R2 mixed");
        done = 1'b1;
        summary();
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
        end
    end

endmodule